// File: doc/BRIEF.md
# Vsync-Triggered Counter Resynchronizer

This block lets one raster timing generator lock its frame start to another pipe's frame. It watches the vertical sync lines of several source pipes and picks one of them with a select field. Each line passes through a two-flop synchronizer. When the chosen line shows the enabled edge, the block asks the local raster counters to jump to their end-of-frame values, so that the next pixel clock begins a fresh frame aligned to the source.

The edge used (rising, falling, or either) comes from two enable bits. Control software normally sets them to match the local vsync polarity: falling for active-low sync, rising otherwise. A two-bit force mode arms the block, and only the resynchronize-on-trigger mode acts. A trigger produces a one-cycle load strobe. With it come a horizontal load value equal to the horizontal total, and a vertical load value equal to the vertical total in progressive scan or one less in interlaced scan. A sticky flag records that a forced load took place and stays set until a clear pulse. The raster counters that consume the strobe live outside this block.

Top module: `vsync_resync_trigger`

## Requirements
- R1: Only the source whose index equals `src_sel` can cause a trigger; edges on any other source line leave `load_stb` and `occurred` unchanged.
- R2: With `trig_rise_en` = 1, a 0-to-1 transition of the selected source causes a trigger.
- R3: With `trig_fall_en` = 1, a 1-to-0 transition of the selected source causes a trigger; with both enables at 0 no transition causes a trigger.
- R4: Only `force_mode` = 2'd2 (resynchronize on trigger) acts; values 2'd0 (off), 2'd1 and 2'd3 produce no strobe and do not set `occurred`.
- R5: On a trigger, `load_h` takes the value of `h_total`.
- R6: On a trigger, `load_v` takes `v_total` when `interlace` = 0 and `v_total` minus one when `interlace` = 1.
- R7: `load_stb` is high for exactly one cycle, starting at the third rising clock edge after the source line changes (the line being stable before the first of those edges).
- R8: `occurred` rises at the same edge as `load_stb` and stays high until a clear.
- R9: `occ_clear` high at a clock edge clears `occurred`, unless a trigger is registered at that same edge, in which case `occurred` stays high.
- R10: After reset `load_stb`, `occurred`, `load_h` and `load_v` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_vsync | input | NUM_SRC | Asynchronous vsync lines of the source pipes |
| src_sel | input | SEL_W | Index of the source pipe to follow |
| trig_rise_en | input | 1 | Trigger on a rising edge of the selected source |
| trig_fall_en | input | 1 | Trigger on a falling edge of the selected source |
| force_mode | input | 2 | 2'd2 arms resynchronization; other values disable it |
| h_total | input | H_W | Local horizontal total |
| v_total | input | V_W | Local vertical total |
| interlace | input | 1 | 1 selects interlaced scan |
| occ_clear | input | 1 | Clears the occurred flag |
| load_stb | output | 1 | One-cycle counter load request |
| load_h | output | H_W | Horizontal load value |
| load_v | output | V_W | Vertical load value |
| occurred | output | 1 | Sticky flag: a forced load has taken place |

## Verification
If the edge-history register of a source holds a wrong value, a spurious or missing strobe shows on `load_stb` within three cycles of the next transition on that line. A mis-steered select, enable or mode decode also shows within three cycles, as an extra or missing strobe and a wrong `occurred`. A wrong sticky state shows on `occurred` at the next edge, whether it is lost early or survives a clear. The bench therefore brings out every trigger through the strobe window and the flag. It also checks the exact strobe cycle, the load values for both scan types, and the case where a trigger and a clear land at the same edge.

// File: rtl/tsync_pkg.sv
// Shared constants for the vsync resynchronizer.
// Assumes a two-bit force mode field in which one code arms the trigger.
package tsync_pkg;
    typedef enum logic [1:0] {
        FORCE_OFF      = 2'd0,
        FORCE_RSVD1    = 2'd1,
        FORCE_ON_TRIG  = 2'd2,
        FORCE_RSVD3    = 2'd3
    } force_mode_e;
endpackage

// File: rtl/tsync_edge_detect.sv
// Synchronizes one asynchronous vsync line with a two-flop chain and
// produces single-cycle rising and falling edge pulses.
// Assumes the line holds each level for at least two clocks.
module tsync_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // Metastability chain followed by one register of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], line_i};
            last_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    // Edge pulses from the synchronized level and its history.
    always_comb begin
        rise_o = chain_q[SYNC_STAGES-1] & ~last_q;
        fall_o = ~chain_q[SYNC_STAGES-1] & last_q;
    end

    assert_one_edge_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> !fall_o);
    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/tsync_force_unit.sv
// Decides whether a selected edge is a trigger and registers the
// counter load strobe with the end-of-frame load values.
// Assumes v_total is at least 1 when interlace is set.
module tsync_force_unit
    import tsync_pkg::*;
#(
    parameter int H_W = 14,
    parameter int V_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rise_i,
    input  logic           fall_i,
    input  logic           rise_en_i,
    input  logic           fall_en_i,
    input  logic [1:0]     mode_i,
    input  logic [H_W-1:0] h_total_i,
    input  logic [V_W-1:0] v_total_i,
    input  logic           interlace_i,
    output logic           fire_o,
    output logic           stb_o,
    output logic [H_W-1:0] load_h_o,
    output logic [V_W-1:0] load_v_o
);
    localparam logic [V_W-1:0] V_ONE = V_W'(1);

    logic edge_hit;

    // Trigger qualification by edge enables and force mode.
    always_comb begin
        edge_hit = (rise_en_i & rise_i) | (fall_en_i & fall_i);
        fire_o   = edge_hit && (force_mode_e'(mode_i) == FORCE_ON_TRIG);
    end

    // Strobe and load values registered on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_o    <= 1'b0;
            load_h_o <= '0;
            load_v_o <= '0;
        end else begin
            stb_o <= fire_o;
            if (fire_o) begin
                load_h_o <= h_total_i;
                load_v_o <= interlace_i ? (v_total_i - V_ONE) : v_total_i;
            end
        end
    end

    assert_mode_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> ($past(mode_i) == 2'd2));
    assert_no_enable_no_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en_i && !fall_en_i) |=> !stb_o);
    assert_load_h_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> (load_h_o == $past(h_total_i)));
endmodule

// File: rtl/tsync_occ_flag.sv
// Sticky record that a forced count load took place.
// Assumes set and clear are synchronous single-cycle requests; set wins.
module tsync_occ_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/vsync_resync_trigger.sv
// Top of the vsync resynchronizer: one edge detector per source pipe,
// selection of the followed pipe, trigger decision and sticky flag.
// Assumes src_vsync lines are asynchronous and slow relative to clk.
module vsync_resync_trigger #(
    parameter int NUM_SRC = 4,
    parameter int H_W     = 14,
    parameter int V_W     = 14,
    parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_vsync,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               trig_rise_en,
    input  logic               trig_fall_en,
    input  logic [1:0]         force_mode,
    input  logic [H_W-1:0]     h_total,
    input  logic [V_W-1:0]     v_total,
    input  logic               interlace,
    input  logic               occ_clear,
    output logic               load_stb,
    output logic [H_W-1:0]     load_h,
    output logic [V_W-1:0]     load_v,
    output logic               occurred
);
    logic [NUM_SRC-1:0] rise_vec;
    logic [NUM_SRC-1:0] fall_vec;
    logic               sel_rise;
    logic               sel_fall;
    logic               fire;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        tsync_edge_detect #(.SYNC_STAGES(2)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (src_vsync[g]),
            .rise_o (rise_vec[g]),
            .fall_o (fall_vec[g])
        );
    end

    // Pick the edge pulses of the followed pipe.
    always_comb begin
        sel_rise = rise_vec[src_sel];
        sel_fall = fall_vec[src_sel];
    end

    tsync_force_unit #(.H_W(H_W), .V_W(V_W)) u_force (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (sel_rise),
        .fall_i      (sel_fall),
        .rise_en_i   (trig_rise_en),
        .fall_en_i   (trig_fall_en),
        .mode_i      (force_mode),
        .h_total_i   (h_total),
        .v_total_i   (v_total),
        .interlace_i (interlace),
        .fire_o      (fire),
        .stb_o       (load_stb),
        .load_h_o    (load_h),
        .load_v_o    (load_v)
    );

    tsync_occ_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fire),
        .clr_i  (occ_clear),
        .flag_o (occurred)
    );

    assert_stb_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> occurred);
    assert_other_pipe_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_vec[src_sel] && !fall_vec[src_sel]) |=> !load_stb);
endmodule

// File: tb/vsync_resync_trigger_tb.sv
`timescale 1ns/1ps
module vsync_resync_trigger_tb;
    localparam int NUM_SRC = 4;
    localparam int H_W = 14;
    localparam int V_W = 14;

    typedef struct packed {
        logic [1:0]     sel;
        logic           ren;
        logic           fen;
        logic [1:0]     mode;
        logic           ilace;
        logic [H_W-1:0] ht;
        logic [V_W-1:0] vt;
        logic           go_high;
        logic           fire;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 1'b1, 1'b0, 2'd2, 1'b0, 14'd800,   14'd525,   1'b1, 1'b1},
        '{2'd1, 1'b0, 1'b1, 2'd2, 1'b1, 14'd2200,  14'd1125,  1'b0, 1'b1},
        '{2'd2, 1'b1, 1'b0, 2'd2, 1'b0, 14'd640,   14'd480,   1'b0, 1'b0},
        '{2'd3, 1'b1, 1'b1, 2'd2, 1'b1, 14'd100,   14'd20,    1'b0, 1'b1},
        '{2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 14'd300,   14'd200,   1'b1, 1'b0},
        '{2'd1, 1'b1, 1'b0, 2'd1, 1'b0, 14'd300,   14'd200,   1'b1, 1'b0},
        '{2'd2, 1'b0, 1'b0, 2'd2, 1'b0, 14'd300,   14'd200,   1'b1, 1'b0},
        '{2'd3, 1'b1, 1'b0, 2'd3, 1'b0, 14'd300,   14'd200,   1'b1, 1'b0},
        '{2'd2, 1'b0, 1'b1, 2'd2, 1'b0, 14'd16383, 14'd16383, 1'b0, 1'b1},
        '{2'd0, 1'b1, 1'b0, 2'd2, 1'b1, 14'd5,     14'd1,     1'b1, 1'b1}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_SRC-1:0] src_vsync;
    logic [1:0]         src_sel;
    logic               trig_rise_en, trig_fall_en;
    logic [1:0]         force_mode;
    logic [H_W-1:0]     h_total;
    logic [V_W-1:0]     v_total;
    logic               interlace;
    logic               occ_clear;
    logic               load_stb;
    logic [H_W-1:0]     load_h;
    logic [V_W-1:0]     load_v;
    logic               occurred;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vsync_resync_trigger #(.NUM_SRC(NUM_SRC), .H_W(H_W), .V_W(V_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_vsync(src_vsync), .src_sel(src_sel),
        .trig_rise_en(trig_rise_en), .trig_fall_en(trig_fall_en),
        .force_mode(force_mode), .h_total(h_total), .v_total(v_total),
        .interlace(interlace), .occ_clear(occ_clear), .load_stb(load_stb),
        .load_h(load_h), .load_v(load_v), .occurred(occurred)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Toggle one source line and watch six cycles; returns strobe count,
    // the sample index of the first strobe, and the loads seen with it.
    task automatic toggle_watch(input int idx, input logic lvl,
                                output int cnt, output int first,
                                output logic [H_W-1:0] sh, output logic [V_W-1:0] sv);
        cnt = 0; first = -1; sh = '0; sv = '0;
        src_vsync[idx] = lvl;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (load_stb) begin
                cnt++;
                if (first < 0) begin
                    first = i; sh = load_h; sv = load_v;
                end
            end
        end
    endtask

    // Disarm, settle the line levels, clear the flag, then apply a configuration.
    task automatic prepare(input vec_t v);
        force_mode = 2'd0;
        src_vsync = v.go_high ? '0 : '1;
        wait_neg(5);
        occ_clear = 1'b1; wait_neg(1); occ_clear = 1'b0;
        src_sel = v.sel; trig_rise_en = v.ren; trig_fall_en = v.fen;
        force_mode = v.mode; interlace = v.ilace; h_total = v.ht; v_total = v.vt;
        wait_neg(1);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt, first;
        logic [H_W-1:0] sh;
        logic [V_W-1:0] sv;
        logic [V_W-1:0] exp_v;

        rst_n = 1'b0; src_vsync = '0; src_sel = '0; trig_rise_en = 1'b0;
        trig_fall_en = 1'b0; force_mode = 2'd0; h_total = '0; v_total = '0;
        interlace = 1'b0; occ_clear = 1'b0;
        wait_neg(4);
        // R10: reset state
        check("R10 load_stb", load_stb, 0);
        check("R10 occurred", occurred, 0);
        check("R10 load_h", load_h, 0);
        check("R10 load_v", load_v, 0);
        rst_n = 1'b1;
        wait_neg(2);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < NVEC; k++) begin
            prepare(VEC[k]);
            toggle_watch(VEC[k].sel, VEC[k].go_high, cnt, first, sh, sv);
            check($sformatf("R2/R3/R4 strobe count vec %0d", k), cnt, VEC[k].fire ? 1 : 0);
            check($sformatf("R8 occurred vec %0d", k), occurred, VEC[k].fire ? 1 : 0);
            if (VEC[k].fire) begin
                exp_v = VEC[k].ilace ? VEC[k].vt - V_W'(1) : VEC[k].vt;
                check($sformatf("R7 strobe cycle vec %0d", k), first, 3);
                check($sformatf("R5 load_h vec %0d", k), sh, VEC[k].ht);
                check($sformatf("R6 load_v vec %0d", k), sv, exp_v);
            end
        end

        // R1: edges on non-selected pipes have no effect
        prepare('{2'd1, 1'b1, 1'b1, 2'd2, 1'b0, 14'd10, 14'd10, 1'b1, 1'b1});
        toggle_watch(0, 1'b1, cnt, first, sh, sv);
        toggle_watch(2, 1'b1, cnt, first, sh, sv);
        check("R1 no strobe from other pipe", cnt, 0);
        toggle_watch(3, 1'b1, cnt, first, sh, sv);
        check("R1 no strobe from pipe 3", cnt, 0);
        check("R1 occurred untouched", occurred, 0);
        toggle_watch(1, 1'b1, cnt, first, sh, sv);
        check("R1 selected pipe triggers", cnt, 1);

        // R8: flag holds across idle cycles
        wait_neg(10);
        check("R8 sticky after idle", occurred, 1);
        // R9: clear alone
        occ_clear = 1'b1; wait_neg(1); occ_clear = 1'b0;
        check("R9 clear drops flag", occurred, 0);

        // R9: trigger and clear at the same edge, trigger wins
        src_vsync[1] = 1'b0;
        wait_neg(2);
        check("R9 trigger on fall", occurred, 0);
        wait_neg(1);
        check("R9 falling trigger sets flag", occurred, 1);
        occ_clear = 1'b1; wait_neg(1); occ_clear = 1'b0;
        check("R9 cleared before race", occurred, 0);
        src_vsync[1] = 1'b1;
        wait_neg(2);
        occ_clear = 1'b1;
        wait_neg(1);
        occ_clear = 1'b0;
        check("R9 trigger wins over clear", occurred, 1);
        check("R9 strobe at race edge", load_stb, 1);
        wait_neg(1);
        check("R7 strobe single cycle", load_stb, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule